// File: doc/BRIEF.md
# Triple Observe-Only Scan Chains

This block holds three parallel observe-only shift chains, one for each redundant area of a triplicated design. Each chain watches the copy of the supervisor's outputs that belongs to its area, the area's functional outputs, and the majority and minority voter outputs placed behind each of them. The supervisor snapshots every observed node with one capture command. It then clocks shift commands and compares the three serial bits that come out on each cycle.

A cell is one flip-flop that captures or shifts. There is no update latch. Each observed node is routed straight to its destination port with no register or mux in the way, so the scan logic adds no delay to the functional path. All three chains move together, so the bits that arrive in one cycle describe the same node in each of the three areas. Because the chains are shifted in parallel, a full unload takes one chain length of cycles instead of three.

Top module: `tri_obs_scan`

## Requirements
- R1: While reset is held, and on the first clock after it is released, every chain holds zero and `scan_out` is 0.
- R2: Each `*_thru` output equals the matching `*_obs` input in the same cycle, whatever the scan controls are doing.
- R3: A clock edge with `cap_en` high loads every cell of all three chains from its observed node. Right after that edge, `scan_out[c]` shows chain c's supervisor bit 0.
- R4: Each chain is L = CTRL_W + 3*OUT_W cells long. Position i (0 = nearest `scan_out`) holds supervisor bit i for i < CTRL_W. For i = CTRL_W + 3j + k, it holds output j's module value (k=0), majority voter value (k=1) or minority voter value (k=2).
- R5: A clock edge with only `shift_en` high moves each chain one cell toward `scan_out`. A clock edge with neither command high leaves every chain unchanged.
- R6: The far end of each chain fills with 0 on every shift. After L shifts, `scan_out` reads 0 until the next capture.
- R7: When `cap_en` and `shift_en` are both high, the capture takes place and the shift is dropped.
- R8: Chain c (c = 0..2) observes only slice c of each input vector: `ctrl_obs[c*CTRL_W +: CTRL_W]` and `*_obs[c*OUT_W +: OUT_W]`. It reports on `scan_out[c]`, and the three chains shift in lockstep.
- R9: Changes to observed nodes between captures do not change the captured contents that are being shifted out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; capture and shift occur on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_en | input | 1 | Capture command from the supervisor |
| shift_en | input | 1 | Shift command from the supervisor |
| ctrl_obs | input | 3*CTRL_W | Supervisor output copy for each area |
| mod_obs | input | 3*OUT_W | Module outputs for each area |
| maj_obs | input | 3*OUT_W | Majority voter outputs for each area |
| min_obs | input | 3*OUT_W | Minority voter outputs for each area |
| ctrl_thru | output | 3*CTRL_W | Unregistered pass-through of ctrl_obs |
| mod_thru | output | 3*OUT_W | Unregistered pass-through of mod_obs |
| maj_thru | output | 3*OUT_W | Unregistered pass-through of maj_obs |
| min_thru | output | 3*OUT_W | Unregistered pass-through of min_obs |
| scan_out | output | 3 | Serial output (cell 0) of each chain |

## Verification
The pass-through outputs are combinational, so the bench compares them in the same cycle it changes the inputs. Every chain result has a latency of exactly one edge: the captured supervisor bit 0 appears right after the capturing edge, and after n shift edges `scan_out` shows position n. The bench drives commands between edges, waits for one rising edge, and samples 1 ns later. Its expected bit for each position comes from the layout in R4, applied to a snapshot of the inputs taken at the capture.

// File: rtl/tri_obs_scan.sv
module tri_obs_scan #(
  parameter int CTRL_W = 2,
  parameter int OUT_W  = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cap_en,
  input  logic                shift_en,
  input  logic [3*CTRL_W-1:0] ctrl_obs,
  input  logic [3*OUT_W-1:0]  mod_obs,
  input  logic [3*OUT_W-1:0]  maj_obs,
  input  logic [3*OUT_W-1:0]  min_obs,
  output logic [3*CTRL_W-1:0] ctrl_thru,
  output logic [3*OUT_W-1:0]  mod_thru,
  output logic [3*OUT_W-1:0]  maj_thru,
  output logic [3*OUT_W-1:0]  min_thru,
  output logic [2:0]          scan_out
);
  localparam int L = CTRL_W + 3*OUT_W;

  logic [3*L-1:0] sr, cap_vec, shf_vec;

  assign ctrl_thru = ctrl_obs;
  assign mod_thru  = mod_obs;
  assign maj_thru  = maj_obs;
  assign min_thru  = min_obs;

  for (genvar c = 0; c < 3; c++) begin : g_chain
    for (genvar i = 0; i < CTRL_W; i++) begin : g_ctrl
      assign cap_vec[c*L + i] = ctrl_obs[c*CTRL_W + i];
    end
    for (genvar j = 0; j < OUT_W; j++) begin : g_out
      assign cap_vec[c*L + CTRL_W + 3*j]     = mod_obs[c*OUT_W + j];
      assign cap_vec[c*L + CTRL_W + 3*j + 1] = maj_obs[c*OUT_W + j];
      assign cap_vec[c*L + CTRL_W + 3*j + 2] = min_obs[c*OUT_W + j];
    end
    assign shf_vec[c*L +: L] = {1'b0, sr[c*L+1 +: L-1]};
    assign scan_out[c] = sr[c*L];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        sr <= '0;
    else if (cap_en)   sr <= cap_vec;
    else if (shift_en) sr <= shf_vec;
  end
endmodule

// File: rtl/tri_obs_scan_chk.sv
module tri_obs_scan_chk #(
  parameter int CTRL_W = 2,
  parameter int OUT_W  = 3
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          cap_en,
  input logic                          shift_en,
  input logic [3*CTRL_W-1:0]           ctrl_obs,
  input logic [2:0]                    scan_out,
  input logic [3*(CTRL_W+3*OUT_W)-1:0] chain
);
  localparam int L = CTRL_W + 3*OUT_W;

  a_r1_reset_clear: assert property (@(posedge clk) $rose(rst_n) |-> (chain == '0 && scan_out == 3'b000));

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_en && !shift_en) |=> $stable(chain));

  for (genvar c = 0; c < 3; c++) begin : g_c
    a_r3_capture_head: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_en && !shift_en) |=> scan_out[c] == $past(ctrl_obs[c*CTRL_W]));
    a_r7_capture_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_en && shift_en) |=> scan_out[c] == $past(ctrl_obs[c*CTRL_W]));
    a_r5_shift_step: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_en && !cap_en) |=> scan_out[c] == $past(chain[c*L+1]));
    a_r6_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_en && !cap_en) |=> chain[c*L+L-1] == 1'b0);
  end
endmodule

bind tri_obs_scan tri_obs_scan_chk #(.CTRL_W(CTRL_W), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .shift_en(shift_en),
  .ctrl_obs(ctrl_obs), .scan_out(scan_out), .chain(sr)
);

// File: tb/tri_obs_scan_test.sv
`timescale 1ns/1ps
module tri_obs_scan_test;
  localparam int CW = 2;
  localparam int OW = 3;
  localparam int L  = CW + 3*OW;

  logic clk = 0, rst_n = 0, cap_en = 0, shift_en = 0;
  logic [3*CW-1:0] ctrl_obs = '0, ctrl_thru;
  logic [3*OW-1:0] mod_obs = '0, maj_obs = '0, min_obs = '0;
  logic [3*OW-1:0] mod_thru, maj_thru, min_thru;
  logic [2:0] scan_out;
  logic [3*CW-1:0] s_ctrl;
  logic [3*OW-1:0] s_mod, s_maj, s_min;
  int runs = 0, fails = 0;

  always #2 clk = ~clk;

  tri_obs_scan #(.CTRL_W(CW), .OUT_W(OW)) uut (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .shift_en(shift_en),
    .ctrl_obs(ctrl_obs), .mod_obs(mod_obs), .maj_obs(maj_obs), .min_obs(min_obs),
    .ctrl_thru(ctrl_thru), .mod_thru(mod_thru), .maj_thru(maj_thru), .min_thru(min_thru),
    .scan_out(scan_out)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    runs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic c, input logic s);
    cap_en = c; shift_en = s;
    @(posedge clk); #1;
    cap_en = 0; shift_en = 0;
  endtask

  task automatic drive(input logic [3*CW-1:0] c, input logic [3*OW-1:0] m, a, n);
    ctrl_obs = c; mod_obs = m; maj_obs = a; min_obs = n;
  endtask

  task automatic snap();
    s_ctrl = ctrl_obs; s_mod = mod_obs; s_maj = maj_obs; s_min = min_obs;
  endtask

  function automatic logic exp_bit(input int c, input int i);
    int k;
    if (i >= L) return 1'b0;
    if (i < CW) return s_ctrl[c*CW + i];
    k = i - CW;
    case (k % 3)
      0: return s_mod[c*OW + k/3];
      1: return s_maj[c*OW + k/3];
      default: return s_min[c*OW + k/3];
    endcase
  endfunction

  function automatic logic [2:0] exp_out(input int i);
    return {exp_bit(2, i), exp_bit(1, i), exp_bit(0, i)};
  endfunction

  task automatic t_reset();
    rst_n = 0;
    drive('1, '1, '1, '1);
    step(1, 0);
    chk(scan_out == 3'b000, "R1 held reset", scan_out, 0);
    rst_n = 1;
    step(0, 0);
    chk(scan_out == 3'b000, "R1 after release", scan_out, 0);
  endtask

  task automatic t_pass(input logic [3*CW-1:0] c, input logic [3*OW-1:0] m, a, n);
    drive(c, m, a, n);
    cap_en = 1; shift_en = 1; #0.5;
    chk({ctrl_thru, mod_thru, maj_thru, min_thru} == {c, m, a, n}, "R2 pass-through",
        {ctrl_thru, mod_thru[4:0]}, {c, m[4:0]});
    cap_en = 0; shift_en = 0;
  endtask

  task automatic t_unload(input logic [3*CW-1:0] c, input logic [3*OW-1:0] m, a, n);
    drive(c, m, a, n);
    step(1, 0);
    snap();
    chk(scan_out == exp_out(0), "R3 capture head", scan_out, exp_out(0));
    drive(~c, ~m, ~a, ~n);
    for (int i = 1; i <= L; i++) begin
      step(0, 1);
      chk(scan_out == exp_out(i), i < L ? "R4 R8 R9 unload order" : "R6 zero fill",
          scan_out, exp_out(i));
    end
    step(0, 1);
    chk(scan_out == 3'b000, "R6 stays zero", scan_out, 0);
  endtask

  task automatic t_hold();
    drive(6'b011001, 9'b101100111, 9'b010011000, 9'b111000101);
    step(1, 0);
    snap();
    step(0, 1);
    for (int i = 0; i < 3; i++) begin
      step(0, 0);
      chk(scan_out == exp_out(1), "R5 hold", scan_out, exp_out(1));
    end
    step(0, 1);
    chk(scan_out == exp_out(2), "R5 single step", scan_out, exp_out(2));
  endtask

  task automatic t_priority();
    drive(6'b101010, 9'b000111000, 9'b111000111, 9'b100100100);
    step(1, 0);
    step(0, 1);
    step(0, 1);
    drive(6'b010101, 9'b110011001, 9'b001100110, 9'b011011011);
    step(1, 1);
    snap();
    chk(scan_out == exp_out(0), "R7 capture wins", scan_out, exp_out(0));
    step(0, 1);
    chk(scan_out == exp_out(1), "R7 fresh data", scan_out, exp_out(1));
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_pass(6'b100101, 9'b110010011, 9'b001101100, 9'b101010101);
    t_unload(6'b100101, 9'b110010011, 9'b001101100, 9'b101010101);
    t_unload(6'b111000, 9'b000000111, 9'b000111000, 9'b111000000);
    t_unload('1, '1, '1, '1);
    t_hold();
    t_priority();
    t_pass('0, 9'b011110001, '1, 9'b100001110);
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule